// File: doc/BRIEF.md
# Resistor-Ladder Key Decoder

This block converts two 12-bit analog readings, each taken across a resistor-ladder key network, into one 32-bit key bitmap. One channel reads the unit's own buttons and the other reads a wired remote. Each reading is checked against a fixed set of value windows. A reading that falls inside a window raises the flag for that key. The windows do not touch, and the dead zones between them give no key.

Two discrete play-button inputs are merged into the same word. Keys from the unit's own panel occupy the lower half of the word. Keys from the remote occupy the upper half. A key decoded on a channel reaches the output only after a configurable number of consecutive valid samples agree on it. The output is registered and comes with a single-cycle change pulse.

Top module: `keyLadderDecoder`

## Requirements
- R1: While `rstN` is low, and on the first cycle after it rises, `keyMap` is 0 and `keyChanged` is 0.
- R2: Panel channel windows map to `keyMap` bits as follows: 1950–2250 to bit 13, 1600–1900 to bit 2, 1250–1550 to bit 1, 900–1200 to bit 3, 550–850 to bit 4 and 200–500 to bit 5.
- R3: Remote channel windows map to `keyMap` bits as follows: 1930–2070 to bit 31, 1230–1370 to bit 18, 830–970 to bit 17, 480–620 to bit 19 and 230–370 to bit 20.
- R4: Both window bounds are inclusive. Any reading outside every window of its channel, including 0 and 4095, decodes to no key on that channel.
- R5: `intPlay` high sets bit 0 and `remPlay` high sets bit 16. Each is captured at the next clock edge, with no debouncing.
- R6: The ladder bits of a channel change only at the clock edge that captures the DEBOUNCE-th consecutive valid sample (default 3) with the same decoded result. A cycle whose valid strobe is low leaves that channel's run and its output bits unchanged, whatever the sample value.
- R7: A valid sample whose decoded result differs from the run in progress restarts the count at one, so no change is made until DEBOUNCE matching samples follow.
- R8: `keyChanged` is 1 in exactly those cycles in which `keyMap` holds a value different from the previous cycle.
- R9: Each half of `keyMap` holds at most one ladder key flag. These are bits 1–15 in the lower half and bits 17–31 in the upper half.
- R10: The two channels are debounced independently. Activity on one channel does not alter the run or the output bits of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| intSample | input | 12 | Panel ladder reading |
| intValid | input | 1 | Panel reading valid strobe |
| remSample | input | 12 | Remote ladder reading |
| remValid | input | 1 | Remote reading valid strobe |
| intPlay | input | 1 | Panel play button, active high |
| remPlay | input | 1 | Remote play button, active high |
| keyMap | output | 32 | Registered key bitmap |
| keyChanged | output | 1 | One-cycle pulse when `keyMap` takes a new value |

## Verification
A corrupted run counter or candidate register shows up at the ports as a key flag that arrives one or more samples early or late. It can also show up as a flag that never appears, and the error is visible within DEBOUNCE valid samples of the disturbance. A wrong window bound shows as a missing or wrong flag on the first committed sample at that reading. A stale change flag is exposed in the very cycle after a map update, because the pulse must last exactly one cycle.

// File: rtl/keyLadderPkg.sv
package keyLadderPkg;

  localparam int SAMPLE_W = 12;
  localparam int MAP_W    = 32;
  localparam int CHANNELS = 2;
  localparam int INT_KEYS = 6;
  localparam int REM_KEYS = 5;

  typedef logic [SAMPLE_W-1:0] sample_t;
  typedef logic [MAP_W-1:0]    keyMap_t;

  // Panel ladder windows (inclusive) and their bitmap positions.
  localparam sample_t INT_LO [INT_KEYS] = '{12'd1950, 12'd1600, 12'd1250, 12'd900, 12'd550, 12'd200};
  localparam sample_t INT_HI [INT_KEYS] = '{12'd2250, 12'd1900, 12'd1550, 12'd1200, 12'd850, 12'd500};
  localparam int      INT_BIT[INT_KEYS] = '{13, 2, 1, 3, 4, 5};

  // Remote ladder windows (inclusive) and their bitmap positions.
  localparam sample_t REM_LO [REM_KEYS] = '{12'd1930, 12'd1230, 12'd830, 12'd480, 12'd230};
  localparam sample_t REM_HI [REM_KEYS] = '{12'd2070, 12'd1370, 12'd970, 12'd620, 12'd370};
  localparam int      REM_BIT[REM_KEYS] = '{31, 18, 17, 19, 20};

  localparam int INT_PLAY_BIT = 0;
  localparam int REM_PLAY_BIT = 16;

  // Strobes from the debounce control to the datapath, one bit per channel.
  typedef struct packed {
    logic [CHANNELS-1:0] load;
    logic [CHANNELS-1:0] commit;
  } ladderCtl_t;

endpackage

// File: rtl/keyWindowDecoder.sv
module keyWindowDecoder
  import keyLadderPkg::*;
#(
  parameter int CHANNEL = 0
) (
  input  sample_t sample,
  output keyMap_t code
);

  localparam int NKEYS = (CHANNEL == 0) ? INT_KEYS : REM_KEYS;

  keyMap_t part [NKEYS];

  for (genvar i = 0; i < NKEYS; i++) begin : g_win
    if (CHANNEL == 0) begin : g_int
      assign part[i] = (sample >= INT_LO[i] && sample <= INT_HI[i])
                       ? (keyMap_t'(1) << INT_BIT[i]) : '0;
    end else begin : g_rem
      assign part[i] = (sample >= REM_LO[i] && sample <= REM_HI[i])
                       ? (keyMap_t'(1) << REM_BIT[i]) : '0;
    end
  end

  always_comb begin
    code = '0;
    for (int k = 0; k < NKEYS; k++) begin
      code = code | part[k];
    end
  end

endmodule

// File: rtl/keyDebounceCtl.sv
module keyDebounceCtl
  import keyLadderPkg::*;
#(
  parameter int DEBOUNCE = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [CHANNELS-1:0] sampleValid,
  input  logic [CHANNELS-1:0] candMatch,
  output ladderCtl_t          ctl
);

  localparam int CNT_W = $clog2(DEBOUNCE + 1);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(DEBOUNCE);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CHANNELS-1:0] loadV;
  logic [CHANNELS-1:0] commitV;

  for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_chan
    logic [CNT_W-1:0] runCnt;
    logic [CNT_W-1:0] cntNext;
    logic             sameRun;
    logic             atTop;

    assign sameRun = candMatch[ch] && (runCnt != '0);
    assign atTop   = (runCnt == CNT_TOP);

    always_comb begin
      cntNext = runCnt;
      if (sampleValid[ch]) begin
        if (!sameRun) begin
          cntNext = CNT_ONE;
        end else if (!atTop) begin
          cntNext = runCnt + CNT_ONE;
        end
      end
    end

    assign loadV[ch]   = sampleValid[ch] && !sameRun;
    assign commitV[ch] = sampleValid[ch] && (cntNext == CNT_TOP) && !(sameRun && atTop);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        runCnt <= '0;
      end else begin
        runCnt <= cntNext;
      end
    end
  end

  always_comb begin
    ctl.load   = loadV;
    ctl.commit = commitV;
  end

endmodule

// File: rtl/keyMapDatapath.sv
module keyMapDatapath
  import keyLadderPkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  keyMap_t             intCode,
  input  keyMap_t             remCode,
  input  logic                intPlay,
  input  logic                remPlay,
  input  ladderCtl_t          ctl,
  output logic [CHANNELS-1:0] candMatch,
  output keyMap_t             keyMap,
  output logic                keyChanged
);

  keyMap_t intCand, remCand;
  keyMap_t intStable, remStable;
  keyMap_t intStableNext, remStableNext;
  keyMap_t mapNext, mapReg;
  logic    changedReg;

  assign candMatch[0] = (intCode == intCand);
  assign candMatch[1] = (remCode == remCand);

  assign intStableNext = ctl.commit[0] ? intCode : intStable;
  assign remStableNext = ctl.commit[1] ? remCode : remStable;

  always_comb begin
    mapNext = intStableNext | remStableNext;
    mapNext[INT_PLAY_BIT] = intPlay;
    mapNext[REM_PLAY_BIT] = remPlay;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      intCand    <= '0;
      remCand    <= '0;
      intStable  <= '0;
      remStable  <= '0;
      mapReg     <= '0;
      changedReg <= 1'b0;
    end else begin
      if (ctl.load[0]) intCand <= intCode;
      if (ctl.load[1]) remCand <= remCode;
      intStable  <= intStableNext;
      remStable  <= remStableNext;
      mapReg     <= mapNext;
      changedReg <= (mapNext != mapReg);
    end
  end

  assign keyMap     = mapReg;
  assign keyChanged = changedReg;

  AST_CHANGE_MEANS_NEW: assert property (@(posedge clk) disable iff (!rstN)
    keyChanged |-> (keyMap != $past(keyMap))); // R8
  AST_NEW_MEANS_CHANGE: assert property (@(posedge clk) disable iff (!rstN)
    (keyMap != $past(keyMap)) |-> keyChanged); // R8
  AST_INT_ONE_KEY: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(keyMap[15:1])); // R9
  AST_REM_ONE_KEY: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(keyMap[31:17])); // R9

endmodule

// File: rtl/keyLadderDecoder.sv
module keyLadderDecoder
  import keyLadderPkg::*;
#(
  parameter int DEBOUNCE = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [11:0] intSample,
  input  logic        intValid,
  input  logic [11:0] remSample,
  input  logic        remValid,
  input  logic        intPlay,
  input  logic        remPlay,
  output logic [31:0] keyMap,
  output logic        keyChanged
);

  keyMap_t             intCode, remCode;
  logic [CHANNELS-1:0] candMatch;
  ladderCtl_t          ctl;

  keyWindowDecoder #(.CHANNEL(0)) u_intDec (.sample(intSample), .code(intCode));
  keyWindowDecoder #(.CHANNEL(1)) u_remDec (.sample(remSample), .code(remCode));

  keyDebounceCtl #(.DEBOUNCE(DEBOUNCE)) u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .sampleValid({remValid, intValid}),
    .candMatch  (candMatch),
    .ctl        (ctl)
  );

  keyMapDatapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .intCode   (intCode),
    .remCode   (remCode),
    .intPlay   (intPlay),
    .remPlay   (remPlay),
    .ctl       (ctl),
    .candMatch (candMatch),
    .keyMap    (keyMap),
    .keyChanged(keyChanged)
  );

  AST_INT_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !intValid |=> (keyMap[15:1] == $past(keyMap[15:1]))); // R6
  AST_REM_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !remValid |=> (keyMap[31:17] == $past(keyMap[31:17]))); // R6

endmodule

// File: tb/keyLadderDecoder_tb.sv
module keyLadderDecoder_tb;

  localparam int DEB = 3;

  logic        clk = 1'b0;
  logic        rstN;
  logic [11:0] intSample, remSample;
  logic        intValid, remValid, intPlay, remPlay;
  logic [31:0] keyMap;
  logic        keyChanged;

  int checks = 0;
  int failures = 0;

  // Reference state
  logic [31:0] mCand [2];
  int          mCnt  [2];
  logic [31:0] mStable [2];
  logic [31:0] expMap;
  logic        expChg;

  always #5 clk = ~clk;

  keyLadderDecoder #(.DEBOUNCE(DEB)) u_dut (
    .clk(clk), .rstN(rstN),
    .intSample(intSample), .intValid(intValid),
    .remSample(remSample), .remValid(remValid),
    .intPlay(intPlay), .remPlay(remPlay),
    .keyMap(keyMap), .keyChanged(keyChanged)
  );

  function automatic logic [31:0] decInt(input int v);
    if (v >= 200  && v <= 500)  return 32'h0000_0020;
    if (v >= 550  && v <= 850)  return 32'h0000_0010;
    if (v >= 900  && v <= 1200) return 32'h0000_0008;
    if (v >= 1250 && v <= 1550) return 32'h0000_0002;
    if (v >= 1600 && v <= 1900) return 32'h0000_0004;
    if (v >= 1950 && v <= 2250) return 32'h0000_2000;
    return 32'h0;
  endfunction

  function automatic logic [31:0] decRem(input int v);
    if (v >= 230  && v <= 370)  return 32'h0010_0000;
    if (v >= 480  && v <= 620)  return 32'h0008_0000;
    if (v >= 830  && v <= 970)  return 32'h0002_0000;
    if (v >= 1230 && v <= 1370) return 32'h0004_0000;
    if (v >= 1930 && v <= 2070) return 32'h8000_0000;
    return 32'h0;
  endfunction

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic modelStep(input logic [31:0] c0, input logic v0,
                           input logic [31:0] c1, input logic v1,
                           input logic ip, input logic rp);
    logic [31:0] c [2];
    logic        v [2];
    logic [31:0] nm;
    c[0] = c0; c[1] = c1; v[0] = v0; v[1] = v1;
    for (int ch = 0; ch < 2; ch++) begin
      if (v[ch]) begin
        if (mCnt[ch] != 0 && c[ch] == mCand[ch]) begin
          if (mCnt[ch] < DEB) begin
            mCnt[ch]++;
            if (mCnt[ch] == DEB) mStable[ch] = c[ch];
          end
        end else begin
          mCand[ch] = c[ch];
          mCnt[ch]  = 1;
          if (mCnt[ch] == DEB) mStable[ch] = c[ch];
        end
      end
    end
    nm = mStable[0] | mStable[1];
    nm[0]  = ip;
    nm[16] = rp;
    expChg = (nm != expMap);
    expMap = nm;
  endtask

  // One cycle: drive after negedge, let the edge pass, check at next negedge.
  task automatic cyc(input int iS, input logic iV, input int rS, input logic rV,
                     input logic ip, input logic rp);
    intSample = iS[11:0]; intValid = iV;
    remSample = rS[11:0]; remValid = rV;
    intPlay = ip; remPlay = rp;
    modelStep(decInt(iS), iV, decRem(rS), rV, ip, rp);
    @(posedge clk);
    @(negedge clk);
    check(keyMap == expMap, "R6 map", keyMap, expMap);
    check(keyChanged == expChg, "R8 change", {31'b0, keyChanged}, {31'b0, expChg});
    check($countones(keyMap[15:1]) <= 1 && $countones(keyMap[31:17]) <= 1,
          "R9 onehot", keyMap, expMap);
  endtask

  task automatic pressInt(input int v);
    for (int i = 0; i < DEB; i++) cyc(v, 1'b1, 0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic pressRem(input int v);
    for (int i = 0; i < DEB; i++) cyc(0, 1'b0, v, 1'b1, 1'b0, 1'b0);
  endtask

  int intLo[6] = '{200, 550, 900, 1250, 1600, 1950};
  int intHi[6] = '{500, 850, 1200, 1550, 1900, 2250};
  logic [31:0] intFl[6] = '{32'h20, 32'h10, 32'h08, 32'h02, 32'h04, 32'h2000};
  int remLo[5] = '{230, 480, 830, 1230, 1930};
  int remHi[5] = '{370, 620, 970, 1370, 2070};
  logic [31:0] remFl[5] = '{32'h0010_0000, 32'h0008_0000, 32'h0002_0000, 32'h0004_0000, 32'h8000_0000};

  function automatic int pickVal(input bit remote);
    int k;
    int r;
    r = int'($urandom_range(0, 9));
    if (r < 3) return int'($urandom_range(0, 4095));
    if (!remote) begin
      k = int'($urandom_range(0, 5));
      if (r == 3) return intLo[k];
      if (r == 4) return intHi[k];
      return int'($urandom_range(intLo[k], intHi[k]));
    end
    k = int'($urandom_range(0, 4));
    if (r == 3) return remLo[k];
    if (r == 4) return remHi[k];
    return int'($urandom_range(remLo[k], remHi[k]));
  endfunction

  initial begin
    #2_000_000;
    checks++;
    failures++;
    $display("FAIL watchdog R6 actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int iHold, rHold, iVal, rVal;
    logic ip, rp;
    void'($urandom(32'd20240611));
    rstN = 1'b0;
    intSample = '0; remSample = '0;
    intValid = 1'b0; remValid = 1'b0; intPlay = 1'b0; remPlay = 1'b0;
    for (int ch = 0; ch < 2; ch++) begin
      mCand[ch] = '0; mCnt[ch] = 0; mStable[ch] = '0;
    end
    expMap = '0; expChg = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset holds outputs clear even with inputs active
    intPlay = 1'b1; intValid = 1'b1; intSample = 12'd300;
    @(negedge clk);
    check(keyMap == 32'h0, "R1 reset map", keyMap, 32'h0);
    check(keyChanged == 1'b0, "R1 reset chg", {31'b0, keyChanged}, 32'h0);
    intPlay = 1'b0; intValid = 1'b0; intSample = '0;
    rstN = 1'b1;
    cyc(0, 1'b0, 0, 1'b0, 1'b0, 1'b0);
    check(keyMap == 32'h0, "R1 after release", keyMap, 32'h0);

    // R6: no change before the third sample, change on it
    cyc(200, 1'b1, 0, 1'b0, 1'b0, 1'b0);
    cyc(200, 1'b1, 0, 1'b0, 1'b0, 1'b0);
    check(keyMap == 32'h0, "R6 early", keyMap, 32'h0);
    cyc(200, 1'b1, 0, 1'b0, 1'b0, 1'b0);
    check(keyMap == 32'h20, "R2 low bound", keyMap, 32'h20);
    check(keyChanged == 1'b1, "R8 pulse", {31'b0, keyChanged}, 32'h1);
    cyc(200, 1'b1, 0, 1'b0, 1'b0, 1'b0);
    check(keyChanged == 1'b0, "R8 one cycle", {31'b0, keyChanged}, 32'h0);

    // R2 and R4: every panel window at both bounds
    for (int k = 0; k < 6; k++) begin
      pressInt(intLo[k]);
      check(keyMap == intFl[k], "R2 lo", keyMap, intFl[k]);
      pressInt(intHi[k]);
      check(keyMap == intFl[k], "R4 hi", keyMap, intFl[k]);
    end
    // R4: gaps and extremes give no key
    pressInt(199);  check(keyMap == 32'h0, "R4 gap 199", keyMap, 32'h0);
    pressInt(1200); pressInt(1201); check(keyMap == 32'h0, "R4 gap 1201", keyMap, 32'h0);
    pressInt(2251); check(keyMap == 32'h0, "R4 gap 2251", keyMap, 32'h0);
    pressInt(4095); check(keyMap == 32'h0, "R4 top", keyMap, 32'h0);

    // R3: every remote window at both bounds
    for (int k = 0; k < 5; k++) begin
      pressRem(remLo[k]);
      check(keyMap == remFl[k], "R3 lo", keyMap, remFl[k]);
      pressRem(remHi[k]);
      check(keyMap == remFl[k], "R3 hi", keyMap, remFl[k]);
    end
    pressRem(371); check(keyMap == 32'h0, "R4 rem gap", keyMap, 32'h0);
    pressRem(0);   check(keyMap == 32'h0, "R4 rem zero", keyMap, 32'h0);

    // R7: an odd sample restarts the run
    cyc(700, 1'b1, 0, 1'b0, 1'b0, 1'b0);
    cyc(700, 1'b1, 0, 1'b0, 1'b0, 1'b0);
    cyc(1000, 1'b1, 0, 1'b0, 1'b0, 1'b0);
    cyc(700, 1'b1, 0, 1'b0, 1'b0, 1'b0);
    cyc(700, 1'b1, 0, 1'b0, 1'b0, 1'b0);
    check(keyMap == 32'h0, "R7 restart", keyMap, 32'h0);
    cyc(700, 1'b1, 0, 1'b0, 1'b0, 1'b0);
    check(keyMap == 32'h10, "R7 after run", keyMap, 32'h10);

    // R6: idle cycles with other sample values do not break the run
    cyc(1000, 1'b1, 0, 1'b0, 1'b0, 1'b0);
    cyc(300, 1'b0, 0, 1'b0, 1'b0, 1'b0);
    cyc(1000, 1'b1, 0, 1'b0, 1'b0, 1'b0);
    cyc(4000, 1'b0, 0, 1'b0, 1'b0, 1'b0);
    check(keyMap == 32'h10, "R6 idle ignored", keyMap, 32'h10);
    cyc(1000, 1'b1, 0, 1'b0, 1'b0, 1'b0);
    check(keyMap == 32'h08, "R6 idle ignored", keyMap, 32'h08);

    // R10: remote commits while panel key held
    pressRem(900);
    check(keyMap == 32'h0002_0008, "R10 independent", keyMap, 32'h0002_0008);

    // R5: play inputs after one edge, no debounce
    cyc(0, 1'b0, 0, 1'b0, 1'b1, 1'b0);
    check(keyMap == 32'h0002_0009, "R5 int play", keyMap, 32'h0002_0009);
    cyc(0, 1'b0, 0, 1'b0, 1'b0, 1'b1);
    check(keyMap == 32'h0003_0008, "R5 rem play", keyMap, 32'h0003_0008);

    // Random traffic against the reference model
    iHold = 0; rHold = 0; iVal = 0; rVal = 0; ip = 1'b0; rp = 1'b0;
    for (int n = 0; n < 3000; n++) begin
      if (iHold == 0) begin iVal = pickVal(1'b0); iHold = int'($urandom_range(1, 5)); end
      if (rHold == 0) begin rVal = pickVal(1'b1); rHold = int'($urandom_range(1, 5)); end
      if ($urandom_range(0, 9) == 0) ip = ~ip;
      if ($urandom_range(0, 9) == 0) rp = ~rp;
      begin
        logic iv, rv;
        iv = ($urandom_range(0, 3) != 0);
        rv = ($urandom_range(0, 3) != 0);
        if (iv) iHold--;
        if (rv) rHold--;
        cyc(iVal, iv, rVal, rv, ip, rp);
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule